// File: doc/BRIEF.md
# Instruction Cycle Controller with Interrupts

This block is the multicycle control sequencer of a small accumulator machine. Programs and data sit together in one read-write memory that is reached only by word address. Every instruction goes through the same state graph. The controller forms the instruction address, fetches the word into the instruction register and decodes it. It then forms each operand address and reads or writes the operand. After that it applies the operation to the accumulator and, if interrupts are allowed, checks for a pending interrupt. Execution is sequential unless a branch or an interrupt return reloads the program counter.

All memory traffic goes through a memory address register and a memory buffer register over a request/ready handshake. A request is held until the memory answers, so any memory latency works. Some instructions read two operands or write two results. For these the operand address and access states run once per operand. A single interrupt line is honoured only when the external enable input and the internal enable flag are both set. When the interrupt is taken, the return address is saved to a fixed location and control moves to a fixed handler address.

Top module: `instr_cycle_ctl`

## Requirements
- R1: A synchronous active-high reset sets the program counter, the accumulator and the interrupt-enable flag to zero, and no memory request is made while reset is held.
- R2: Each instruction begins with a memory read at the program counter. The program counter is one higher after that fetch, so instructions run in address order.
- R3: A memory request keeps its address, write flag and write data unchanged until `mem_ready` is seen high. Each accepted handshake is exactly one access, and it lands at the address held in the address register.
- R4: The opcode is bits [DW-1:DW-4] and the address field is bits [AW-1:0]. Codes: 0 no-op, 1 load (acc = M[a]), 2 store (M[a] = acc), 3 add (acc = acc + M[a], modulo 2^DW), 4 branch, 5 return-from-interrupt, 6 halt, 7 dual add, 8 dual store, 9 enable interrupts. Unlisted codes act as no-op.
- R5: Dual add (7) reads M[a] and then M[a+1] and adds both to the accumulator. Dual store (8) writes the accumulator to M[a] and then to M[a+1].
- R6: Branch (4) loads the program counter with the address field, and the next fetch comes from that address.
- R7: When an instruction ends with `irq` high, `irq_en` high and the enable flag set as it was when the instruction began, the controller writes the program counter to SAVE_ADDR. It then loads HANDLER_ADDR and clears the enable flag before the next fetch.
- R8: When the enable flag is clear or `irq_en` is low, `irq` has no effect: no save write is made and the next fetch comes from the program counter.
- R9: Return-from-interrupt (5) reads SAVE_ADDR, loads the program counter from the low AW bits of that word and sets the enable flag. Code 9 sets the flag. In both cases the new flag value first counts at the end of the following instruction.
- R10: After halt (6) no further memory request is made and the program counter does not change until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | AW | Access address (address register) |
| mem_wdata | output | DW | Write data (buffer register) |
| mem_rdata | input | DW | Read data |
| mem_ready | input | 1 | Memory completes the pending access |
| irq | input | 1 | Interrupt request level |
| irq_en | input | 1 | External interrupt enable |
| pc_o | output | AW | Program counter |
| acc_o | output | DW | Accumulator |
| ie_o | output | 1 | Internal interrupt-enable flag |
| halted | output | 1 | Halt state reached |

## Verification
The bench builds the controller with AW=8 (so DW=12), SAVE_ADDR=8'hF0 and HANDLER_ADDR=8'hC0. This keeps a full 256-word memory model in the bench and lets the word wrap during additions within a short program. A behavioural model runs each program at instruction level ahead of time and produces the exact order of memory accesses. That order is compared at every handshake, while ready latencies of zero to three cycles vary throughout the run. The programs cover an interrupt taken in the middle of the program and returned from, a request ignored while the flag is clear, and the same request masked by `irq_en`.

// File: rtl/instr_cycle_ctl.sv
module instr_cycle_ctl #(
  parameter int AW = 12,
  parameter logic [AW-1:0] SAVE_ADDR = 'h00F,
  parameter logic [AW-1:0] HANDLER_ADDR = 'h010,
  localparam int DW = AW + 4
) (
  input  logic          clk,
  input  logic          rst,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  input  logic          mem_ready,
  input  logic          irq,
  input  logic          irq_en,
  output logic [AW-1:0] pc_o,
  output logic [DW-1:0] acc_o,
  output logic          ie_o,
  output logic          halted
);
  localparam logic [3:0] S_IAC = 4'd0, S_IF = 4'd1, S_DEC = 4'd2, S_OAC = 4'd3,
                         S_OF = 4'd4, S_DO = 4'd5, S_OS = 4'd6, S_ICHK = 4'd7,
                         S_INT = 4'd8, S_HLT = 4'd9;
  localparam logic [3:0] OP_LD = 4'd1, OP_ST = 4'd2, OP_ADD = 4'd3, OP_BR = 4'd4,
                         OP_RTI = 4'd5, OP_HLT = 4'd6, OP_ADD2 = 4'd7, OP_ST2 = 4'd8,
                         OP_EI = 4'd9;

  logic [3:0]    state;
  logic [AW-1:0] pc, mar;
  logic [DW-1:0] ir, mbr, acc;
  logic          ie, idx;

  wire [3:0]    op    = ir[DW-1:DW-4];
  wire [AW-1:0] fa    = ir[AW-1:0];
  wire          dual  = (op == OP_ADD2) || (op == OP_ST2);
  wire          is_rd = (op == OP_LD) || (op == OP_ADD) || (op == OP_ADD2) || (op == OP_RTI);
  wire          is_wr = (op == OP_ST) || (op == OP_ST2);
  wire          last  = (idx == dual);
  wire [3:0]    end_next = (irq_en && ie) ? S_ICHK : S_IAC;
  wire          in_fetch = (state == S_IF);

  assign mem_req   = in_fetch || (state == S_OF) || (state == S_OS) || (state == S_INT);
  assign mem_we    = (state == S_OS) || (state == S_INT);
  assign mem_addr  = mar;
  assign mem_wdata = mbr;
  assign pc_o      = pc;
  assign acc_o     = acc;
  assign ie_o      = ie;
  assign halted    = (state == S_HLT);

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= S_IAC;
      pc    <= '0;
      mar   <= '0;
      ir    <= '0;
      mbr   <= '0;
      acc   <= '0;
      ie    <= 1'b0;
      idx   <= 1'b0;
    end else begin
      case (state)
        S_IAC: begin
          mar   <= pc;
          state <= S_IF;
        end
        S_IF: if (mem_ready) begin
          ir    <= mem_rdata;
          pc    <= pc + 1'b1;
          state <= S_DEC;
        end
        S_DEC: begin
          idx <= 1'b0;
          if (op == OP_HLT)  state <= S_HLT;
          else if (is_rd)    state <= S_OAC;
          else               state <= S_DO;
        end
        S_OAC: begin
          mar   <= (op == OP_RTI) ? SAVE_ADDR : fa + AW'(idx);
          state <= is_wr ? S_OS : S_OF;
        end
        S_OF: if (mem_ready) begin
          mbr <= idx ? mbr + mem_rdata : mem_rdata;
          if (last) state <= S_DO;
          else begin
            idx   <= 1'b1;
            state <= S_OAC;
          end
        end
        S_DO: begin
          case (op)
            OP_LD:           acc <= mbr;
            OP_ADD, OP_ADD2: acc <= acc + mbr;
            OP_BR:           pc  <= fa;
            OP_RTI: begin
              pc <= mbr[AW-1:0];
              ie <= 1'b1;
            end
            OP_EI:           ie  <= 1'b1;
            OP_ST, OP_ST2:   mbr <= acc;
            default: ;
          endcase
          state <= is_wr ? S_OAC : end_next;
        end
        S_OS: if (mem_ready) begin
          if (last) state <= end_next;
          else begin
            idx   <= 1'b1;
            state <= S_OAC;
          end
        end
        S_ICHK: begin
          if (irq) begin
            mar   <= SAVE_ADDR;
            mbr   <= DW'(pc);
            state <= S_INT;
          end else state <= S_IAC;
        end
        S_INT: if (mem_ready) begin
          pc    <= HANDLER_ADDR;
          ie    <= 1'b0;
          state <= S_IAC;
        end
        default: state <= S_HLT;
      endcase
    end
  end
endmodule

// File: rtl/instr_cycle_ctl_chk.sv
module instr_cycle_ctl_chk #(
  parameter int AW = 12,
  parameter logic [AW-1:0] SAVE_ADDR = 'h00F,
  parameter logic [AW-1:0] HANDLER_ADDR = 'h010,
  localparam int DW = AW + 4
) (
  input logic          clk,
  input logic          rst,
  input logic          mem_req,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic [DW-1:0] mem_wdata,
  input logic          mem_ready,
  input logic [AW-1:0] pc_o,
  input logic          ie_o,
  input logic          halted,
  input logic          in_fetch
);
  // R1
  reset_clear_chk: assert property (@(posedge clk)
    $past(rst) |-> (pc_o == '0) && !ie_o && !mem_req);

  // R3
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    mem_req && !mem_ready |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));

  // R2
  fetch_step_chk: assert property (@(posedge clk) disable iff (rst)
    in_fetch && mem_ready |=> pc_o == $past(mem_addr) + AW'(1));

  // R7
  int_entry_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(ie_o) |-> (pc_o == HANDLER_ADDR) &&
                    $past(mem_req && mem_we && mem_ready && (mem_addr == SAVE_ADDR)));

  // R10
  halt_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    halted |=> halted && !mem_req && $stable(pc_o));
endmodule

bind instr_cycle_ctl instr_cycle_ctl_chk #(
  .AW(AW), .SAVE_ADDR(SAVE_ADDR), .HANDLER_ADDR(HANDLER_ADDR)
) u_chk (.*);

// File: tb/instr_cycle_ctl_tb.sv
module instr_cycle_ctl_tb;
  localparam int AW = 8;
  localparam int DW = 12;
  localparam logic [7:0] SAVE = 8'hF0;
  localparam logic [7:0] HAND = 8'hC0;

  logic clk = 0, rst = 1;
  logic mem_req, mem_we, mem_ready = 0, irq = 0, irq_en = 0, halted, ie_o;
  logic [AW-1:0] mem_addr, pc_o;
  logic [DW-1:0] mem_wdata, mem_rdata, acc_o;

  logic [DW-1:0] bmem [256];
  int rm [256];
  int qa[$], qw[$], qd[$];
  string qt[$];
  int checks = 0, failures = 0, cycles = 0;
  int exp_pc, exp_acc, exp_ie, trig, wait_cnt = 0, seed = 0;
  bit run = 0;

  always #10 clk = ~clk;

  assign mem_rdata = bmem[mem_addr];

  instr_cycle_ctl #(.AW(AW), .SAVE_ADDR(SAVE), .HANDLER_ADDR(HAND)) u_dut (
    .clk(clk), .rst(rst), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ready(mem_ready), .irq(irq),
    .irq_en(irq_en), .pc_o(pc_o), .acc_o(acc_o), .ie_o(ie_o), .halted(halted));

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic push(input int a, input int w, input int d, input string t);
    qa.push_back(a & 255); qw.push_back(w); qd.push_back(d & 'hFFF); qt.push_back(t);
  endtask

  function automatic int ins(input int op, input int a);
    return (op << 8) | (a & 255);
  endfunction

  task automatic model(input bit en);
    int pc = 0, acc = 0, w, op, a;
    bit ie = 0, pend = 0, iec;
    string ft = "R2";
    qa.delete(); qw.delete(); qd.delete(); qt.delete();
    for (int i = 0; i < 256; i++) rm[i] = int'(bmem[i]);
    for (int n = 0; n < 500; n++) begin
      push(pc, 0, 0, ft);
      ft = "R2";
      w = rm[pc];
      if (pc == trig) pend = 1;
      pc = (pc + 1) & 255;
      op = w >> 8; a = w & 255; iec = ie;
      if (op == 6) break;
      case (op)
        1: begin push(a, 0, 0, "R4"); acc = rm[a]; end
        3: begin push(a, 0, 0, "R4"); acc = (acc + rm[a]) & 'hFFF; end
        7: begin
          push(a, 0, 0, "R5"); push(a + 1, 0, 0, "R5");
          acc = (acc + rm[a] + rm[(a + 1) & 255]) & 'hFFF;
        end
        2: begin push(a, 1, acc, "R4"); rm[a] = acc; end
        8: begin
          push(a, 1, acc, "R5"); push(a + 1, 1, acc, "R5");
          rm[a] = acc; rm[(a + 1) & 255] = acc;
        end
        4: begin pc = a; ft = "R6"; end
        5: begin push(SAVE, 0, 0, "R9"); pc = rm[SAVE] & 255; ie = 1; end
        9: ie = 1;
        default: ;
      endcase
      if (en && iec && pend) begin
        push(SAVE, 1, pc, "R7");
        rm[SAVE] = pc; pc = HAND; ie = 0; pend = 0;
      end
    end
    exp_pc = pc; exp_acc = acc; exp_ie = ie;
  endtask

  always @(posedge clk) cycles++;

  always @(negedge clk) begin
    if (run && mem_req) begin
      if (wait_cnt == 0) begin
        mem_ready <= 1;
        if (qa.size() == 0) check("R3 unexpected access", int'(mem_addr), -1);
        else begin
          check({qt[0], " addr"}, int'(mem_addr), qa[0]);
          check({qt[0], " write flag"}, int'(mem_we), qw[0]);
          if (qw[0] == 1) check({qt[0], " write data"}, int'(mem_wdata), qd[0]);
          void'(qa.pop_front()); void'(qw.pop_front()); void'(qd.pop_front()); void'(qt.pop_front());
        end
        if (mem_we) bmem[mem_addr] = mem_wdata;
        if (!mem_we && int'(mem_addr) == trig) irq <= 1;
        if (mem_we && mem_addr == SAVE) irq <= 0;
        seed++;
        wait_cnt = (seed * 7 + 3) % 4;
      end else begin
        mem_ready <= 0;
        wait_cnt--;
      end
    end else mem_ready <= 0;
  end

  initial begin
    #1;
    forever begin
      @(negedge clk);
      if (cycles > 150000) begin
        failures++;
        $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
      end
    end
  end

  task automatic do_reset();
    run = 0; rst = 1; irq = 0; wait_cnt = 0;
    repeat (2) @(negedge clk);
    check("R1 reset pc", int'(pc_o), 0);
    check("R1 reset acc", int'(acc_o), 0);
    check("R1 reset ie", int'(ie_o), 0);
    check("R1 reset no request", int'(mem_req), 0);
  endtask

  task automatic exec(input string name, input bit en, input int tg, input string qtag);
    int pc_hold, n;
    trig = tg; irq_en = en;
    model(en);
    do_reset();
    run = 1; rst = 0;
    n = 0;
    while (!halted && n < 5000) begin @(negedge clk); n++; end
    check({"R10 halt reached ", name}, int'(halted), 1);
    check({"R2 final pc ", name}, int'(pc_o), exp_pc);
    check({"R4 final acc ", name}, int'(acc_o), exp_acc);
    check({"R9 final ie ", name}, int'(ie_o), exp_ie);
    check({qtag, " remaining accesses ", name}, qa.size(), 0);
    pc_hold = int'(pc_o);
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      check("R10 no request after halt", int'(mem_req), 0);
      check("R10 pc frozen after halt", int'(pc_o), pc_hold);
    end
  endtask

  task automatic clear_mem();
    for (int i = 0; i < 256; i++) bmem[i] = '0;
  endtask

  initial begin
    // Program A: arithmetic, dual operands, branch; irq high but flag clear (R8)
    clear_mem();
    bmem[0] = DW'(ins(1, 'h80)); bmem[1] = DW'(ins(3, 'h81)); bmem[2] = DW'(ins(7, 'h82));
    bmem[3] = DW'(ins(2, 'h90)); bmem[4] = DW'(ins(8, 'h92)); bmem[5] = DW'(ins(1, 'h93));
    bmem[6] = DW'(ins(4, 'h0A)); bmem[7] = DW'(ins(6, 0));
    bmem['h0A] = DW'(ins(3, 'h90)); bmem['h0B] = DW'(ins(7, 'h84)); bmem['h0C] = DW'(ins(6, 0));
    bmem['h80] = 12'd5; bmem['h81] = 12'd7; bmem['h82] = 12'd3; bmem['h83] = 12'd4;
    bmem['h84] = 12'hFF0; bmem['h85] = 12'h020;
    exec("progA", 1'b1, 0, "R8");

    // Program B: interrupt taken after ADD, handler, return (R7, R9)
    clear_mem();
    bmem[0] = DW'(ins(9, 0)); bmem[1] = DW'(ins(1, 'h80)); bmem[2] = DW'(ins(3, 'h81));
    bmem[3] = DW'(ins(2, 'h90)); bmem[4] = DW'(ins(6, 0));
    bmem[HAND] = DW'(ins(7, 'h82)); bmem[HAND + 1] = DW'(ins(2, 'h91)); bmem[HAND + 2] = DW'(ins(5, 0));
    bmem['h80] = 12'd10; bmem['h81] = 12'd20; bmem['h82] = 12'd1; bmem['h83] = 12'd2;
    exec("progB", 1'b1, 2, "R7");

    // Program C: same image with the external enable low (R8)
    clear_mem();
    bmem[0] = DW'(ins(9, 0)); bmem[1] = DW'(ins(1, 'h80)); bmem[2] = DW'(ins(3, 'h81));
    bmem[3] = DW'(ins(2, 'h90)); bmem[4] = DW'(ins(6, 0));
    bmem[HAND] = DW'(ins(7, 'h82)); bmem[HAND + 1] = DW'(ins(2, 'h91)); bmem[HAND + 2] = DW'(ins(5, 0));
    bmem['h80] = 12'd10; bmem['h81] = 12'd20;
    exec("progC", 1'b0, 2, "R8");
    check("R8 no save write with irq_en low", int'(bmem[SAVE]), 0);

    do_reset();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule